// File: doc/BRIEF.md
# Fetch-Stage Direction and Target Predictor

This block tells the fetch unit where to go next. Each fetch address is looked up in two tables at once. The first is a direct-mapped direction table with one bit per entry, indexed by low address bits. The second is a direct-mapped target cache whose entries carry a valid flag, an address tag and a cached target. When the direction bit says "taken" and the target cache hits, the predicted next address is the cached target, so fetch can redirect without a stall. In every other case the predicted next address is the sequential one (address plus 4).

A later pipeline stage returns each resolved branch on the update port. It supplies the branch address, the real outcome, the real target, and the prediction that was made for that branch at fetch. The block then does three things:
- It compares the carried prediction with the real next address and raises a mispredict pulse together with the correct restart address.
- It inverts the direction bit when the direction was guessed wrong.
- It writes or refreshes the target entry for every taken branch.

The direction bits carry no tag. Branches that share low address bits therefore share one bit. This can lower accuracy but never correctness, because a wrong guess is always caught at resolution.

Top module: `bpred_top`

## Requirements
- R1: After a synchronous reset, `pr_valid` and `mispredict` are 0. Every direction bit reads 0 (not taken) and every target entry is invalid, so the first lookup of any address predicts not-taken with next address = address + 4.
- R2: A lookup presented with `lk_valid` = 1 on one rising edge yields `pr_valid` = 1 exactly two rising edges later. When the result is not a redirect, `pr_next_pc` = looked-up address + 4.
- R3: `pr_taken` is the direction bit selected by address bits [2 +: log2(HIST_ENTRIES)] of the looked-up address. No tag is compared on this bit.
- R4: An update whose `up_taken` differs from `up_pred_taken` sets the direction bit at the branch's index to `up_taken`, which inverts it. An update whose direction was guessed right leaves the bit unchanged.
- R5: Two addresses that agree in the index bits share one direction bit. Training one changes the prediction for the other.
- R6: `pr_next_pc` equals the cached target only when `pr_taken` = 1 and the target entry at index bits [2 +: log2(BTB_ENTRIES)] is valid and its tag equals the address bits above that index. Otherwise `pr_next_pc` = address + 4.
- R7: A taken update writes the target entry with the valid flag, the branch tag and `up_target`, replacing any older target. A not-taken update leaves the target cache untouched.
- R8: One rising edge after an update, `mispredict` = 1 exactly when the real next address (`up_target` if taken, else `up_pc` + 4) differs from `up_pred_next`. This covers both a wrong direction and a wrong target. `redirect_pc` then holds the real next address.
- R9: A loop-closing branch that is taken nine times and then not taken, starting from reset, mispredicts exactly twice in its ten executions: on the first and on the last. That is 80 % accuracy.
- R10: A lookup and an update on the same rising edge: the lookup sees the table contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Fetch lookup request |
| lk_pc | input | PC_W | Fetch address to predict |
| pr_valid | output | 1 | Prediction result valid (two edges after request) |
| pr_taken | output | 1 | Direction bit for the looked-up address |
| pr_next_pc | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | Resolved branch report |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real branch outcome |
| up_target | input | PC_W | Real branch target |
| up_pred_taken | input | 1 | Direction predicted at fetch for this branch |
| up_pred_next | input | PC_W | Next address predicted at fetch for this branch |
| mispredict | output | 1 | Restart request, one edge after the update |
| redirect_pc | output | PC_W | Correct restart address, meaningful with `mispredict` |

## Verification
A lookup result appears on `pr_valid`, `pr_taken` and `pr_next_pc` two rising edges after the request. The restart pulse and address appear one rising edge after the update. The bench drives inputs on falling edges. A behavioural model advances on every rising edge, in the same order as the hardware: it first emits the results of the lookup in flight, then reads the tables for the new lookup, and only then applies the update, which also gives the read-before-write rule of R10. The hardware outputs are compared with the model on the following falling edge, once all registers have settled. The directed sequences count edges in the same way: read the prediction two falling edges after the lookup, and the mispredict one falling edge after the update.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  // Instructions are word aligned: the two lowest address bits never index a table.
  localparam int unsigned ALIGN_W     = 2;
  localparam int unsigned INSTR_BYTES = 4;

  // Resolution outcome handed from the resolve unit to the storage units.
  typedef struct packed {
    logic dir_we;   // direction bit must be rewritten
    logic dir_bit;  // value to write
    logic tgt_we;   // target entry must be written
  } bpred_wr_t;

endpackage

// File: rtl/bpred_hist.sv
module bpred_hist #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);

  logic [ENTRIES-1:0] bits_q;

  // One flop per entry so the whole table clears on reset.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        bits_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        bits_q[g] <= wr_bit;
      end
    end
  end

  // Registered read of the pre-write contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bit <= 1'b0;
    end else if (rd_en) begin
      rd_bit <= bits_q[rd_idx];
    end
  end

endmodule

// File: rtl/bpred_btb.sv
module bpred_btb #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = $clog2(ENTRIES),
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned PC_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [PC_W-1:0]    tgt_mem [ENTRIES];

  // Valid flags live in flops so reset can clear them in one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // Tag and target payload: plain RAM, single write port.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  // Synchronous read, read-first with respect to a same-edge write.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag <= tag_mem[rd_idx];
      rd_tgt <= tgt_mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= valid_q[rd_idx];
    end
  end

endmodule

// File: rtl/bpred_resolve.sv
module bpred_resolve
  import bpred_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_pred_taken,
  input  logic [PC_W-1:0] up_pred_next,
  output bpred_wr_t       wr,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);

  logic [PC_W-1:0] actual_next;
  logic            next_wrong;

  always_comb begin
    actual_next = up_taken ? up_target : (up_pc + PC_W'(INSTR_BYTES));
    next_wrong  = (actual_next != up_pred_next);
    wr.dir_we   = up_valid && (up_taken != up_pred_taken);
    wr.dir_bit  = up_taken;
    wr.tgt_we   = up_valid && up_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= up_valid && next_wrong;
      redirect_pc <= actual_next;
    end
  end

endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned HIST_ENTRIES = 64,
  parameter int unsigned BTB_ENTRIES  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pr_valid,
  output logic            pr_taken,
  output logic [PC_W-1:0] pr_next_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_pred_taken,
  input  logic [PC_W-1:0] up_pred_next,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);

  localparam int unsigned HIST_IDX_W = $clog2(HIST_ENTRIES);
  localparam int unsigned BTB_IDX_W  = $clog2(BTB_ENTRIES);
  localparam int unsigned TAG_LSB    = ALIGN_W + BTB_IDX_W;
  localparam int unsigned TAG_W      = PC_W - TAG_LSB;

  // Stage 1: table read in flight.
  logic            s1_valid;
  logic [PC_W-1:0] s1_pc;
  logic            s1_dir;
  logic            s1_bvalid;
  logic [TAG_W-1:0] s1_tag;
  logic [PC_W-1:0] s1_tgt;

  // Stage 2 combinational select.
  logic            s2_hit;
  logic [PC_W-1:0] s2_next;

  bpred_wr_t wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pc    <= '0;
    end else begin
      s1_valid <= lk_valid;
      if (lk_valid) begin
        s1_pc <= lk_pc;
      end
    end
  end

  bpred_hist #(
    .ENTRIES (HIST_ENTRIES),
    .IDX_W   (HIST_IDX_W)
  ) u_hist (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (lk_valid),
    .rd_idx (lk_pc[ALIGN_W +: HIST_IDX_W]),
    .rd_bit (s1_dir),
    .wr_en  (wr.dir_we),
    .wr_idx (up_pc[ALIGN_W +: HIST_IDX_W]),
    .wr_bit (wr.dir_bit)
  );

  bpred_btb #(
    .ENTRIES (BTB_ENTRIES),
    .IDX_W   (BTB_IDX_W),
    .TAG_W   (TAG_W),
    .PC_W    (PC_W)
  ) u_btb (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (lk_valid),
    .rd_idx   (lk_pc[ALIGN_W +: BTB_IDX_W]),
    .rd_valid (s1_bvalid),
    .rd_tag   (s1_tag),
    .rd_tgt   (s1_tgt),
    .wr_en    (wr.tgt_we),
    .wr_idx   (up_pc[ALIGN_W +: BTB_IDX_W]),
    .wr_tag   (up_pc[PC_W-1:TAG_LSB]),
    .wr_tgt   (up_target)
  );

  bpred_resolve #(
    .PC_W (PC_W)
  ) u_resolve (
    .clk           (clk),
    .rst           (rst),
    .up_valid      (up_valid),
    .up_pc         (up_pc),
    .up_taken      (up_taken),
    .up_target     (up_target),
    .up_pred_taken (up_pred_taken),
    .up_pred_next  (up_pred_next),
    .wr            (wr),
    .mispredict    (mispredict),
    .redirect_pc   (redirect_pc)
  );

  always_comb begin
    s2_hit  = s1_bvalid && (s1_tag == s1_pc[PC_W-1:TAG_LSB]);
    s2_next = (s1_dir && s2_hit) ? s1_tgt : (s1_pc + PC_W'(INSTR_BYTES));
  end

  // Stage 2: registered prediction outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid   <= 1'b0;
      pr_taken   <= 1'b0;
      pr_next_pc <= '0;
    end else begin
      pr_valid   <= s1_valid;
      pr_taken   <= s1_valid && s1_dir;
      pr_next_pc <= s2_next;
    end
  end

endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [PC_W-1:0] lk_pc,
  input logic            pr_valid,
  input logic            pr_taken,
  input logic [PC_W-1:0] pr_next_pc,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic [PC_W-1:0] up_target,
  input logic [PC_W-1:0] up_pred_next,
  input logic            mispredict
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!pr_valid && !mispredict));

  assert_pr_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(lk_valid, 2)) |-> pr_valid);

  assert_seq_next_R2: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && !pr_taken) |-> (pr_next_pc == $past(lk_pc, 2) + PC_W'(4)));

  assert_no_update_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> !mispredict);

  assert_right_guess_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (up_valid && (up_pred_next == (up_taken ? up_target : up_pc + PC_W'(4))))
      |=> !mispredict);

endmodule

bind bpred_top bpred_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lk_valid     (lk_valid),
  .lk_pc        (lk_pc),
  .pr_valid     (pr_valid),
  .pr_taken     (pr_taken),
  .pr_next_pc   (pr_next_pc),
  .up_valid     (up_valid),
  .up_pc        (up_pc),
  .up_taken     (up_taken),
  .up_target    (up_target),
  .up_pred_next (up_pred_next),
  .mispredict   (mispredict)
);

// File: tb/bpred_top_tb.sv
module bpred_top_tb;

  localparam int HIST_N = 64;
  localparam int BTB_N  = 16;
  localparam int TAG_SH = 2 + $clog2(BTB_N);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        pr_valid, pr_taken;
  logic [31:0] pr_next_pc;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;
  logic        up_pred_taken = 1'b0;
  logic [31:0] up_pred_next = '0;
  logic        mispredict;
  logic [31:0] redirect_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bpred_top #(.PC_W(32), .HIST_ENTRIES(HIST_N), .BTB_ENTRIES(BTB_N)) u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_next_pc(pr_next_pc),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
    .up_pred_taken(up_pred_taken), .up_pred_next(up_pred_next),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_dir [HIST_N];
  bit          m_bv  [BTB_N];
  logic [31:0] m_bpc [BTB_N];
  logic [31:0] m_btg [BTB_N];
  bit          s1v, s1t, s1h;
  logic [31:0] s1pc, s1tg;
  bit          e_pv, e_pt, e_mp;
  logic [31:0] e_pn, e_rd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_dir[i]) m_dir[i] = 1'b0;
      foreach (m_bv[i])  m_bv[i]  = 1'b0;
      s1v = 0; s1t = 0; s1h = 0; s1pc = '0; s1tg = '0;
      e_pv = 0; e_pt = 0; e_mp = 0; e_pn = '0; e_rd = '0;
    end else begin
      logic [31:0] act;
      int hi, bi;
      e_pv = s1v;
      e_pt = s1t;
      e_pn = (s1t && s1h) ? s1tg : s1pc + 32'd4;
      if (lk_valid) begin
        hi   = int'((lk_pc >> 2) % HIST_N);
        bi   = int'((lk_pc >> 2) % BTB_N);
        s1pc = lk_pc;
        s1t  = m_dir[hi];
        s1h  = m_bv[bi] && ((m_bpc[bi] >> TAG_SH) == (lk_pc >> TAG_SH));
        s1tg = m_btg[bi];
      end
      s1v  = lk_valid;
      act  = up_taken ? up_target : up_pc + 32'd4;
      e_mp = up_valid && (act != up_pred_next);
      e_rd = act;
      if (up_valid) begin
        if (up_taken != up_pred_taken) m_dir[int'((up_pc >> 2) % HIST_N)] = up_taken;
        if (up_taken) begin
          bi = int'((up_pc >> 2) % BTB_N);
          m_bv[bi]  = 1'b1;
          m_bpc[bi] = up_pc;
          m_btg[bi] = up_target;
        end
      end
    end
  end

  // Compare on every falling edge, after all registers settle.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 pr_valid", 32'(pr_valid), 32'(e_pv));
      if (e_pv) begin
        chk("R3 pr_taken", 32'(pr_taken), 32'(e_pt));
        chk("R6 pr_next_pc", pr_next_pc, e_pn);
      end
      chk("R8 mispredict", 32'(mispredict), 32'(e_mp));
      if (e_mp) chk("R8 redirect_pc", redirect_pc, e_rd);
    end
  end

  // ---------------- directed stimulus helpers ----------------
  task automatic do_look(input logic [31:0] pc, output bit t, output logic [31:0] n);
    lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    t = pr_taken; n = pr_next_pc;
  endtask

  task automatic send_upd(input logic [31:0] pc, input bit tk, input logic [31:0] tg,
                          input bit pt, input logic [31:0] pn, output bit mp);
    up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tg;
    up_pred_taken = pt; up_pred_next = pn;
    @(negedge clk);
    mp = mispredict;
    up_valid = 1'b0;
  endtask

  task automatic do_branch(input logic [31:0] pc, input bit tk, input logic [31:0] tg,
                           output bit mp);
    bit t; logic [31:0] n;
    do_look(pc, t, n);
    send_upd(pc, tk, tg, t, n, mp);
  endtask

  initial begin
    bit t, mp;
    logic [31:0] n;
    int mcount;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 pr_valid after reset", 32'(pr_valid), 32'd0);
    chk("R1 mispredict after reset", 32'(mispredict), 32'd0);
    do_look(32'h1234_5678, t, n);
    chk("R1 first lookup taken", 32'(t), 32'd0);
    chk("R1 first lookup next", n, 32'h1234_567C);

    // R9 / R4: loop branch, nine taken then one not taken
    mcount = 0;
    for (int i = 0; i < 10; i++) begin
      do_branch(32'h100, (i < 9), 32'h80, mp);
      mcount += int'(mp);
      if (i == 0) chk("R4 first iteration mispredict", 32'(mp), 32'd1);
      if (i == 9) chk("R4 loop exit mispredict", 32'(mp), 32'd1);
    end
    chk("R9 mispredicts in ten executions", 32'(mcount), 32'd2);

    // R5: 0x200 aliases 0x100's direction bit; R6 tag miss vs hit
    do_branch(32'h200, 1'b1, 32'h300, mp);
    chk("R5 alias trained from not-taken", 32'(mp), 32'd1);
    do_look(32'h100, t, n);
    chk("R5 alias shares direction bit", 32'(t), 32'd1);
    chk("R6 tag mismatch gives sequential", n, 32'h104);
    do_look(32'h200, t, n);
    chk("R6 tag hit redirects", n, 32'h300);

    // R7: not-taken update leaves the target cache alone
    send_upd(32'h48, 1'b1, 32'h600, 1'b0, 32'h4C, mp);
    chk("R8 wrong direction flagged", 32'(mp), 32'd1);
    send_upd(32'h48, 1'b0, 32'h700, 1'b0, 32'h4C, mp);
    chk("R8 right guess quiet", 32'(mp), 32'd0);
    do_look(32'h48, t, n);
    chk("R4 correct guess keeps bit", 32'(t), 32'd1);
    chk("R7 not-taken keeps target", n, 32'h600);

    // R8: right direction, wrong target; R7 refresh
    send_upd(32'h48, 1'b1, 32'h640, 1'b1, 32'h600, mp);
    chk("R8 wrong target flagged", 32'(mp), 32'd1);
    chk("R8 restart address", redirect_pc, 32'h640);
    do_look(32'h48, t, n);
    chk("R7 target refreshed", n, 32'h640);

    // R10: lookup and update on the same edge
    lk_valid = 1'b1; lk_pc = 32'h60;
    up_valid = 1'b1; up_pc = 32'h60; up_taken = 1'b1; up_target = 32'h800;
    up_pred_taken = 1'b0; up_pred_next = 32'h64;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    chk("R10 same-edge update flagged", 32'(mispredict), 32'd1);
    @(negedge clk);
    chk("R10 lookup sees old direction", 32'(pr_taken), 32'd0);
    chk("R10 lookup sees old target", pr_next_pc, 32'h64);
    do_look(32'h60, t, n);
    chk("R10 later lookup sees update", n, 32'h800);

    // Mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      lk_valid      = r[0];
      lk_pc         = {22'd0, 8'($urandom), 2'b00};
      up_valid      = r[1];
      up_pc         = {22'd0, 8'($urandom), 2'b00};
      up_taken      = r[2];
      up_target     = {20'd0, 10'($urandom), 2'b00};
      up_pred_taken = r[3];
      up_pred_next  = r[4] ? (up_taken ? up_target : up_pc + 32'd4)
                           : {20'd0, 10'($urandom), 2'b00};
      @(negedge clk);
    end
    lk_valid = 1'b0; up_valid = 1'b0;
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule